// File: doc/BRIEF.md
# Lost-Locality Load Throttle

This block sits beside an L1 data cache that is shared by many wavefronts. It watches for one pattern: a wavefront misses on a line that it filled itself and that was evicted a short time before. When the cache evicts a line, the block takes the tag and the ID of the wavefront that filled the line, and it stores the tag in a small set of victim-tag slots that belongs only to that wavefront. On each L1 miss, the block searches the missing wavefront's own slots for the missed line. A match means that wavefront has lost intra-wavefront locality, and its locality score is raised.

Scores decay a little on every cycle. On every cycle the wavefronts are ranked by score, lowest first, and their scores are summed in rank order. A wavefront whose running total goes above a fixed budget has its load-allow bit cleared, so the main issue scheduler stops issuing its loads until the pressure on the cache falls. The wavefront with the lowest score is always allowed.

Top module: `locality_throttle`

## Requirements
- R1: While `rst` is high at a clock edge, all scores are set to 1 and all victim slots are emptied. `load_allow` goes to all ones and `probe_hit` goes to 0.
- R2: An eviction writes `evict_tag` into the victim slots of wavefront `evict_wid` in FIFO order over `VT_DEPTH` slots. When a wavefront has written more than `VT_DEPTH` tags, its oldest slot is overwritten.
- R3: A probe compares the line tag `probe_addr[ADDR_W-1:7]` with the valid slots of wavefront `probe_wid` only. Address bits 6:0 are ignored. `probe_hit` is 1 in the cycle after the probe if a slot matched, and 0 otherwise. It is 0 after a cycle in which `probe_valid` was low.
- R4: A probe hit clears every slot of that wavefront that matched, so a repeat probe of the same line misses.
- R5: A probe hit adds `HIT_INCR` to the probing wavefront's score. In any other cycle the score drops by 1, but never below 1.
- R6: `load_allow` is registered from the scores held before the edge. Wavefronts are ranked by ascending score, and equal scores are ranked by lower index first. A wavefront is allowed if the sum of its own score and the scores of all wavefronts ranked ahead of it is at most `BUDGET`. The first-ranked wavefront is always allowed.
- R7: When a probe and an eviction target the same wavefront in one cycle, the probe searches the slots as they were before the eviction. If the eviction writes a slot that the probe cleared, the newly written tag is kept.
- R8: A score that would exceed 2^`SCORE_W`-1 saturates at that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evict_valid | input | 1 | An L1 line is being evicted this cycle |
| evict_wid | input | $clog2(NUM_WF) | Wavefront that filled the evicted line |
| evict_tag | input | ADDR_W-7 | Line tag of the evicted line |
| probe_valid | input | 1 | An L1 miss is probing this cycle |
| probe_wid | input | $clog2(NUM_WF) | Wavefront that missed |
| probe_addr | input | ADDR_W | Byte address of the miss |
| probe_hit | output | 1 | The previous probe matched a victim slot |
| load_allow | output | NUM_WF | Per-wavefront permission to issue loads |

## Verification
A stale or corrupted victim slot shows up at `probe_hit` in the cycle after the next probe of that wavefront. The same fault also reaches `load_allow` one cycle later, through the score that the slot raised or failed to raise. A wrong score cannot be read directly. It can stay hidden until the ranking puts that wavefront near the budget cutoff, so the bench compares `load_allow` with a reference on every cycle. The budget is kept small, so that a single hit moves the cutoff.

// File: rtl/locality_throttle_pkg.sv
`timescale 1ns/1ps
package locality_throttle_pkg;
  // Cache line geometry: tags drop the byte offset within a line.
  localparam int LINE_BYTES = 128;
  localparam int LINE_OFS_W = $clog2(LINE_BYTES);
  // Score value every wavefront rests at.
  localparam int SCORE_FLOOR = 1;
endpackage

// File: rtl/victim_tag_bank.sv
`timescale 1ns/1ps
module victim_tag_bank #(
  parameter int NUM_WF   = 32,
  parameter int VT_DEPTH = 8,
  parameter int TAG_W    = 25,
  parameter int WID_W    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             probe_valid,
  input  logic [WID_W-1:0] probe_wid,
  input  logic [TAG_W-1:0] probe_tag,
  input  logic             evict_valid,
  input  logic [WID_W-1:0] evict_wid,
  input  logic [TAG_W-1:0] evict_tag,
  output logic             probe_match
);
  localparam int PTR_W = (VT_DEPTH > 1) ? $clog2(VT_DEPTH) : 1;

  logic [NUM_WF-1:0] wf_match;

  for (genvar g = 0; g < NUM_WF; g++) begin : g_wf
    logic [TAG_W-1:0]    tag_q [VT_DEPTH];
    logic [VT_DEPTH-1:0] vld_q;
    logic [VT_DEPTH-1:0] vld_d;
    logic [VT_DEPTH-1:0] hit_vec;
    logic [PTR_W-1:0]    wptr_q;
    logic                probe_sel;
    logic                evict_sel;

    assign probe_sel = probe_valid && (probe_wid == WID_W'(g));
    assign evict_sel = evict_valid && (evict_wid == WID_W'(g));

    always_comb begin
      for (int e = 0; e < VT_DEPTH; e++) begin
        hit_vec[e] = vld_q[e] && (tag_q[e] == probe_tag);
      end
    end

    assign wf_match[g] = probe_sel && (|hit_vec);

    // Probe clears first, then the eviction claims its slot.
    always_comb begin
      vld_d = vld_q;
      if (probe_sel) vld_d = vld_d & ~hit_vec;
      if (evict_sel) vld_d[wptr_q] = 1'b1;
    end

    // Tag storage has no reset so it maps onto plain memory.
    always_ff @(posedge clk) begin
      if (evict_sel) tag_q[wptr_q] <= evict_tag;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q  <= '0;
        wptr_q <= '0;
      end else begin
        vld_q <= vld_d;
        if (evict_sel) begin
          if (wptr_q == PTR_W'(VT_DEPTH - 1)) wptr_q <= '0;
          else                                wptr_q <= wptr_q + PTR_W'(1);
        end
      end
    end
  end

  assign probe_match = |wf_match;
endmodule

// File: rtl/locality_score.sv
`timescale 1ns/1ps
module locality_score
  import locality_throttle_pkg::*;
#(
  parameter int NUM_WF   = 32,
  parameter int WID_W    = 5,
  parameter int SCORE_W  = 10,
  parameter int HIT_INCR = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        hit_valid,
  input  logic [WID_W-1:0]            hit_wid,
  output logic [NUM_WF*SCORE_W-1:0]   scores
);
  localparam logic [SCORE_W:0]   SCORE_MAX = {1'b0, {SCORE_W{1'b1}}};
  localparam logic [SCORE_W:0]   INCR_C    = (SCORE_W + 1)'(HIT_INCR);
  localparam logic [SCORE_W-1:0] FLOOR_C   = SCORE_W'(SCORE_FLOOR);

  for (genvar g = 0; g < NUM_WF; g++) begin : g_wf
    logic [SCORE_W-1:0] s_q;
    logic [SCORE_W:0]   bumped;
    logic               bump;

    assign bump   = hit_valid && (hit_wid == WID_W'(g));
    assign bumped = {1'b0, s_q} + INCR_C;

    always_ff @(posedge clk) begin
      if (rst) begin
        s_q <= FLOOR_C;
      end else if (bump) begin
        s_q <= (bumped > SCORE_MAX) ? SCORE_MAX[SCORE_W-1:0] : bumped[SCORE_W-1:0];
      end else if (s_q > FLOOR_C) begin
        s_q <= s_q - SCORE_W'(1);
      end
    end

    assign scores[g*SCORE_W +: SCORE_W] = s_q;
  end
endmodule

// File: rtl/issue_budget_gate.sv
`timescale 1ns/1ps
module issue_budget_gate #(
  parameter int NUM_WF  = 32,
  parameter int SCORE_W = 10,
  parameter int BUDGET  = 256
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_WF*SCORE_W-1:0] scores,
  output logic [NUM_WF-1:0]         allow
);
  localparam int SUM_W = SCORE_W + $clog2(NUM_WF) + 1;
  localparam logic [SUM_W-1:0] BUDGET_C =
    (BUDGET >= (2 ** SUM_W)) ? {SUM_W{1'b1}} : SUM_W'(BUDGET);

  logic [NUM_WF-1:0] allow_d;

  for (genvar i = 0; i < NUM_WF; i++) begin : g_rank
    logic [SUM_W-1:0]   cum;
    logic               ahead;
    logic [SCORE_W-1:0] own;

    assign own = scores[i*SCORE_W +: SCORE_W];

    // Sum own score plus every wavefront ranked ahead (lower score, or equal and lower index).
    always_comb begin
      cum   = SUM_W'(own);
      ahead = 1'b0;
      for (int j = 0; j < NUM_WF; j++) begin
        if (j != i) begin
          if ((scores[j*SCORE_W +: SCORE_W] < own) ||
              ((scores[j*SCORE_W +: SCORE_W] == own) && (j < i))) begin
            cum   = cum + SUM_W'(scores[j*SCORE_W +: SCORE_W]);
            ahead = 1'b1;
          end
        end
      end
    end

    assign allow_d[i] = !ahead || (cum <= BUDGET_C);
  end

  always_ff @(posedge clk) begin
    if (rst) allow <= '1;
    else     allow <= allow_d;
  end
endmodule

// File: rtl/locality_throttle.sv
`timescale 1ns/1ps
module locality_throttle
  import locality_throttle_pkg::*;
#(
  parameter int NUM_WF   = 32,
  parameter int VT_DEPTH = 8,
  parameter int ADDR_W   = 32,
  parameter int SCORE_W  = 10,
  parameter int HIT_INCR = 64,
  parameter int BUDGET   = 256,
  localparam int WID_W   = $clog2(NUM_WF),
  localparam int TAG_W   = ADDR_W - LINE_OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evict_valid,
  input  logic [WID_W-1:0]  evict_wid,
  input  logic [TAG_W-1:0]  evict_tag,
  input  logic              probe_valid,
  input  logic [WID_W-1:0]  probe_wid,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              probe_hit,
  output logic [NUM_WF-1:0] load_allow
);
  logic [TAG_W-1:0]          probe_tag;
  logic                      probe_match;
  logic [NUM_WF*SCORE_W-1:0] score_flat;
  logic                      unused_ofs;

  assign probe_tag  = probe_addr[ADDR_W-1:LINE_OFS_W];
  assign unused_ofs = ^probe_addr[LINE_OFS_W-1:0];

  victim_tag_bank #(
    .NUM_WF(NUM_WF), .VT_DEPTH(VT_DEPTH), .TAG_W(TAG_W), .WID_W(WID_W)
  ) vtb_i (
    .clk(clk), .rst(rst),
    .probe_valid(probe_valid), .probe_wid(probe_wid), .probe_tag(probe_tag),
    .evict_valid(evict_valid), .evict_wid(evict_wid), .evict_tag(evict_tag),
    .probe_match(probe_match)
  );

  locality_score #(
    .NUM_WF(NUM_WF), .WID_W(WID_W), .SCORE_W(SCORE_W), .HIT_INCR(HIT_INCR)
  ) score_i (
    .clk(clk), .rst(rst),
    .hit_valid(probe_match), .hit_wid(probe_wid),
    .scores(score_flat)
  );

  issue_budget_gate #(
    .NUM_WF(NUM_WF), .SCORE_W(SCORE_W), .BUDGET(BUDGET)
  ) gate_i (
    .clk(clk), .rst(rst),
    .scores(score_flat),
    .allow(load_allow)
  );

  always_ff @(posedge clk) begin
    if (rst) probe_hit <= 1'b0;
    else     probe_hit <= probe_match;
  end
endmodule

// File: rtl/locality_throttle_chk.sv
`timescale 1ns/1ps
module locality_throttle_chk #(
  parameter int NUM_WF  = 32,
  parameter int SCORE_W = 10,
  parameter int BUDGET  = 256
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      probe_valid,
  input logic                      probe_hit,
  input logic [NUM_WF-1:0]         load_allow,
  input logic [NUM_WF*SCORE_W-1:0] scores
);
  logic [31:0] total;
  logic        any_zero;

  always_comb begin
    total    = '0;
    any_zero = 1'b0;
    for (int w = 0; w < NUM_WF; w++) begin
      total = total + 32'(scores[w*SCORE_W +: SCORE_W]);
      if (scores[w*SCORE_W +: SCORE_W] == '0) any_zero = 1'b1;
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> ((&load_allow) && !probe_hit)); // R1

  AST_HIT_AFTER_PROBE: assert property (@(posedge clk) disable iff (rst)
    probe_hit |-> $past(probe_valid)); // R3

  AST_SCORE_FLOOR: assert property (@(posedge clk) disable iff (rst)
    !any_zero); // R5

  AST_SOME_ALLOWED: assert property (@(posedge clk) disable iff (rst)
    (|load_allow)); // R6

  AST_ALL_FIT: assert property (@(posedge clk) disable iff (rst)
    (total <= 32'(BUDGET)) |=> (&load_allow)); // R6
endmodule

bind locality_throttle locality_throttle_chk #(
  .NUM_WF(NUM_WF), .SCORE_W(SCORE_W), .BUDGET(BUDGET)
) chk_i (
  .clk(clk), .rst(rst), .probe_valid(probe_valid), .probe_hit(probe_hit),
  .load_allow(load_allow), .scores(score_flat)
);

// File: tb/locality_throttle_tb_top.sv
`timescale 1ns/1ps
module locality_throttle_tb_top;
  localparam int NWF    = 4;
  localparam int DEP    = 4;
  localparam int AW     = 16;
  localparam int SW     = 8;
  localparam int INC    = 16;
  localparam int BUD    = 20;
  localparam int WW     = 2;
  localparam int TW     = AW - 7;
  localparam int SMAX   = 255;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ev = 1'b0;
  logic [WW-1:0] ew = '0;
  logic [TW-1:0] et = '0;
  logic          pv = 1'b0;
  logic [WW-1:0] pw = '0;
  logic [AW-1:0] pa = '0;
  logic          probe_hit;
  logic [NWF-1:0] load_allow;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  locality_throttle #(
    .NUM_WF(NWF), .VT_DEPTH(DEP), .ADDR_W(AW), .SCORE_W(SW),
    .HIT_INCR(INC), .BUDGET(BUD)
  ) dut_i (
    .clk(clk), .rst(rst),
    .evict_valid(ev), .evict_wid(ew), .evict_tag(et),
    .probe_valid(pv), .probe_wid(pw), .probe_addr(pa),
    .probe_hit(probe_hit), .load_allow(load_allow)
  );

  // Reference state
  int            m_score [NWF];
  logic [TW-1:0] m_tag   [NWF][DEP];
  bit            m_vld   [NWF][DEP];
  int            m_ptr   [NWF];
  logic [NWF-1:0] m_allow;
  bit            m_hit;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int w = 0; w < NWF; w++) begin
      m_score[w] = 1;
      m_ptr[w]   = 0;
      for (int e = 0; e < DEP; e++) m_vld[w][e] = 1'b0;
    end
    m_allow = '1;
    m_hit   = 1'b0;
  endtask

  function automatic logic [NWF-1:0] rank_allow();
    int keys[$];
    int cum;
    logic [NWF-1:0] a;
    a = '0;
    for (int w = 0; w < NWF; w++) keys.push_back(m_score[w] * NWF + w);
    keys.sort();
    cum = 0;
    for (int k = 0; k < NWF; k++) begin
      int w;
      w = keys[k] % NWF;
      cum += m_score[w];
      a[w] = (k == 0) || (cum <= BUD);
    end
    return a;
  endfunction

  task automatic model_step();
    logic [NWF-1:0] na;
    bit hit;
    na  = rank_allow();
    hit = 1'b0;
    if (pv) begin
      for (int e = 0; e < DEP; e++) begin
        if (m_vld[pw][e] && m_tag[pw][e] == pa[AW-1:7]) begin
          hit = 1'b1;
          m_vld[pw][e] = 1'b0;
        end
      end
    end
    if (ev) begin
      m_tag[ew][m_ptr[ew]] = et;
      m_vld[ew][m_ptr[ew]] = 1'b1;
      m_ptr[ew] = (m_ptr[ew] + 1) % DEP;
    end
    for (int w = 0; w < NWF; w++) begin
      if (hit && w == int'(pw)) m_score[w] = (m_score[w] + INC > SMAX) ? SMAX : m_score[w] + INC;
      else if (m_score[w] > 1)  m_score[w] = m_score[w] - 1;
    end
    m_hit   = hit;
    m_allow = na;
  endtask

  // One clock: DUT captures current inputs, reference follows, outputs compared.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    model_step();
    check(probe_hit == m_hit, {"R3 hit ", cur_req}, probe_hit, m_hit);
    check(load_allow == m_allow, {"R6 allow ", cur_req}, load_allow, m_allow);
  endtask

  task automatic idle();
    ev = 1'b0; pv = 1'b0;
  endtask

  task automatic do_evict(input int w, input int t);
    idle(); ev = 1'b1; ew = WW'(w); et = TW'(t); step();
  endtask

  task automatic do_probe(input int w, input int t, input int ofs);
    idle(); pv = 1'b1; pw = WW'(w); pa = {TW'(t), 7'(ofs)}; step();
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(load_allow == '1, "R1 allow in reset", load_allow, 4'hF);
    check(probe_hit == 1'b0, "R1 hit in reset", probe_hit, 0);
    rst = 1'b0;
    model_reset();
    idle(); step();
    check(load_allow == '1, "R1 allow after reset", load_allow, 4'hF);

    // R3: isolation by wavefront, offset bits ignored
    cur_req = "R3";
    do_evict(0, 'h11);
    do_probe(1, 'h11, 'h05);
    check(probe_hit == 1'b0, "R3 other wavefront", probe_hit, 0);
    do_probe(0, 'h11, 'h7F);
    check(probe_hit == 1'b1, "R3 own wavefront", probe_hit, 1);
    // R4: hit clears the slot
    cur_req = "R4";
    do_probe(0, 'h11, 0);
    check(probe_hit == 1'b0, "R4 repeat probe", probe_hit, 0);
    idle(); step();
    check(probe_hit == 1'b0, "R3 no probe no hit", probe_hit, 0);

    // R2: FIFO overwrite of the oldest slot
    cur_req = "R2";
    for (int k = 0; k < 5; k++) do_evict(2, 'h20 + k);
    do_probe(2, 'h20, 0);
    check(probe_hit == 1'b0, "R2 oldest overwritten", probe_hit, 0);
    do_probe(2, 'h21, 0);
    check(probe_hit == 1'b1, "R2 second kept", probe_hit, 1);

    // R7: probe sees contents before a same-cycle eviction
    cur_req = "R7";
    idle(); pv = 1'b1; pw = 2'd3; pa = {TW'('h30), 7'd0};
    ev = 1'b1; ew = 2'd3; et = TW'('h30); step();
    check(probe_hit == 1'b0, "R7 probe before insert", probe_hit, 0);
    do_probe(3, 'h30, 0);
    check(probe_hit == 1'b1, "R7 insert visible later", probe_hit, 1);
    for (int k = 0; k < 4; k++) do_evict(1, 'h40 + k);
    idle(); pv = 1'b1; pw = 2'd1; pa = {TW'('h40), 7'd0};
    ev = 1'b1; ew = 2'd1; et = TW'('h44); step();
    check(probe_hit == 1'b1, "R7 probe hits cleared slot", probe_hit, 1);
    do_probe(1, 'h44, 0);
    check(probe_hit == 1'b1, "R7 new tag kept in slot", probe_hit, 1);

    // R8 / R5: drive wavefront 0 into saturation, then let it decay
    cur_req = "R8";
    for (int k = 0; k < 20; k++) begin
      do_evict(0, 'h50 + k);
      do_probe(0, 'h50 + k, 0);
    end
    idle(); step();
    check(load_allow == 4'b1110, "R6 heavy wavefront throttled", load_allow, 4'b1110);
    cur_req = "R5";
    repeat (200) begin idle(); step(); end
    check(load_allow[0] == 1'b0, "R8 saturated score still high", load_allow[0], 0);
    repeat (100) begin idle(); step(); end
    check(load_allow == 4'hF, "R5 decay restores issue", load_allow, 4'hF);

    // Mixed traffic with a small tag space
    cur_req = "R6";
    for (int k = 0; k < 4000; k++) begin
      idle();
      pv = ($urandom_range(0, 1) == 1);
      pw = WW'($urandom_range(0, NWF - 1));
      pa = {TW'($urandom_range(0, 7)), 7'($urandom_range(0, 127))};
      ev = ($urandom_range(0, 2) != 0);
      ew = WW'($urandom_range(0, NWF - 1));
      et = TW'($urandom_range(0, 7));
      step();
    end

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule